// File: doc/BRIEF.md
# Fixed-Point Complex Stream Multiplier

The block takes two independently flowing streams of complex samples and multiplies them pairwise. Stream A carries the data samples. Stream B carries a unit-magnitude complex tone, and each A sample is rotated by the B sample it is paired with. Each stream handshakes with valid and ready. One A beat and one B beat are consumed together, and only in a cycle where both are offered and the pipeline can move. The two streams therefore stay paired one-to-one and in order, however each one stalls.

Both input words hold the imaginary part in the upper half and the real part in the lower half. An A lane is 24 bits wide and holds a 21-bit signed value with 15 fractional bits in its low bits. A B lane is a 16-bit signed value with 14 fractional bits. The full-precision product is 38 bits per component. The block keeps the upper 32 bits of it, so each output component has 23 fractional bits. Packet boundaries come from stream A only. The pipeline has three register stages and stops as a whole when the output is held off.

Top module: `cmul_stream`

## Requirements
- R1: Each 24-bit A lane is read as the signed 21-bit value in its bits [20:0]. Bits [23:21] of each lane have no effect on the result. The real part is the lane in bits [23:0] and the imaginary part is the lane in bits [47:24].
- R2: B is read as two signed 16-bit lanes, the real part in bits [15:0] and the imaginary part in bits [31:16].
- R3: The output real part in m_data[31:0] equals bits [37:6] of the exact 38-bit value Ia·Ib − Qa·Qb.
- R4: The output imaginary part in m_data[63:32] equals bits [37:6] of the exact 38-bit value Ia·Qb + Qa·Ib.
- R5: A beat is taken from A exactly in the cycles where a beat is taken from B. Results come out in acceptance order, one for each accepted pair. No input is accepted while an output is held off.
- R6: m_last of each result equals the last flag of the A beat it came from. The last flag of stream B has no effect.
- R7: While m_valid is high and m_ready is low, m_valid, m_data and m_last keep their values on the next cycle.
- R8: With m_ready high and the pipeline empty, a pair accepted on a rising edge appears on m_valid after the second rising edge that follows it.
- R9: A cycle with rst_n low leaves m_valid low on the next cycle.
- R10: Full-scale operands give exact results, for example Ia = Qa = −2^20 with Ib = Qb = −2^15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_a_data | input | 48 | Sample stream word, {Q, I} in 24-bit lanes |
| s_a_last | input | 1 | Packet end marker of the sample stream |
| s_a_valid | input | 1 | Sample stream beat offered |
| s_a_ready | output | 1 | Sample stream beat taken |
| s_b_data | input | 32 | Tone stream word, {Q, I} in 16-bit lanes |
| s_b_last | input | 1 | Tone stream marker, ignored |
| s_b_valid | input | 1 | Tone stream beat offered |
| s_b_ready | output | 1 | Tone stream beat taken |
| m_data | output | 64 | Product word, {Q, I} in 32-bit lanes |
| m_last | output | 1 | Packet end marker, copied from the sample stream |
| m_valid | output | 1 | Result offered |
| m_ready | input | 1 | Result taken downstream |

## Verification
The assertions check the handshake rules on every cycle. A beat is never taken from one input without the other, and no input is taken while the output is held off. A held result stays frozen, each stage moves forward when enabled, and reset empties the output. The arithmetic cannot be checked by a property: bit exactness, the ignored guard bits of A, the carried last flag and the pairing order only show up when the bench compares each result with its behavioural model. The bench drives random gaps on both inputs and random backpressure, plus directed full-scale operands and a latency measurement.

// File: rtl/cmul_pkg.sv
// Shared constants for the complex stream multiplier.
// Lane 0 of every word is the real part and lane 1 the imaginary part.
package cmul_pkg;
    typedef enum int {LANE_I = 0, LANE_Q = 1} lane_e;
    localparam int NUM_LANES  = 2;
    localparam int PIPE_DEPTH = 3;
endpackage

// File: rtl/cmul_join.sv
// Joins two valid/ready inputs into one transfer.
// Assumes: adv is high when the pipeline can take a new entry this cycle.
// Each side is granted only when the other side is offering too, so beats
// are always consumed in pairs.
module cmul_join (
    input  logic clk,
    input  logic rst_n,
    input  logic a_valid,
    input  logic b_valid,
    input  logic adv,
    output logic a_ready,
    output logic b_ready,
    output logic fire
);
    // Grant each side only when the partner offers and the pipe moves.
    always_comb begin
        a_ready = b_valid & adv;
        b_ready = a_valid & adv;
        fire    = a_valid & b_valid & adv;
    end

    // R5: a transfer on one side implies one on the other side.
    p_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_ready) |-> (b_valid && b_ready));
    p_pair_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_ready) |-> (a_valid && a_ready));
endmodule

// File: rtl/cmul_lane_split.sv
// Splits a {Q, I} word into two signed parts.
// Assumes: each part sits in the low KEEP_W bits of its LANE_W lane. The
// guard bits above it are don't-care.
module cmul_lane_split #(
    parameter int LANE_W = 24,
    parameter int KEEP_W = 21
) (
    input  logic [2*LANE_W-1:0]      word,
    output logic [1:0][KEEP_W-1:0]   part
);
    localparam int GUARD_W = LANE_W - KEEP_W;

    for (genvar l = 0; l < cmul_pkg::NUM_LANES; l++) begin : g_lane
        // Pick the value bits of this lane.
        assign part[l] = word[l*LANE_W +: KEEP_W];
        if (GUARD_W > 0) begin : g_guard
            logic unused_guard;
            assign unused_guard = ^word[l*LANE_W+KEEP_W +: GUARD_W];
        end
    end
endmodule

// File: rtl/cmul_core.sv
// Three-stage complex product pipeline.
// Stage 1 registers the operands. Stage 2 registers the four partial
// products. Stage 3 registers the combined sums, cut to their upper bits.
// Assumes: en is a single enable for all stages (the whole pipe stalls),
// and in_fire is only high together with en.
module cmul_core #(
    parameter int A_W    = 21,
    parameter int B_W    = 16,
    parameter int DROP_W = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 en,
    input  logic                                 in_fire,
    input  logic                                 in_last,
    input  logic [1:0][A_W-1:0]                  a_part,
    input  logic [1:0][B_W-1:0]                  b_part,
    output logic                                 out_valid,
    output logic                                 out_last,
    output logic [2*(A_W+B_W+1-DROP_W)-1:0]      out_data
);
    localparam int PP_W   = A_W + B_W;
    localparam int PROD_W = PP_W + 1;
    localparam int OUT_W  = PROD_W - DROP_W;
    localparam int LI     = cmul_pkg::LANE_I;
    localparam int LQ     = cmul_pkg::LANE_Q;

    logic                  v1, v2, v3;
    logic                  l1, l2, l3;
    logic [1:0][A_W-1:0]   a1;
    logic [1:0][B_W-1:0]   b1;
    logic [1:0][1:0][PP_W-1:0] pp_d, pp;
    logic signed [PROD_W-1:0]  sum_re, sum_im;
    logic [2*OUT_W-1:0]    res;

    // Valid flags of the three stages, moving only when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            v3 <= 1'b0;
        end else if (en) begin
            v1 <= in_fire;
            v2 <= v1;
            v3 <= v2;
        end
    end

    // Stage 1: capture the operands and the framing flag.
    always_ff @(posedge clk) begin
        if (en) begin
            a1 <= a_part;
            b1 <= b_part;
            l1 <= in_last;
        end
    end

    // One signed partial product for each pair of lanes.
    for (genvar i = 0; i < cmul_pkg::NUM_LANES; i++) begin : g_pa
        for (genvar j = 0; j < cmul_pkg::NUM_LANES; j++) begin : g_pb
            assign pp_d[i][j] = PP_W'($signed(a1[i]) * $signed(b1[j]));
        end
    end

    // Stage 2: register the partial products.
    always_ff @(posedge clk) begin
        if (en) begin
            pp <= pp_d;
            l2 <= l1;
        end
    end

    // Full-precision combination of the partial products.
    always_comb begin
        sum_re = PROD_W'($signed(pp[LI][LI])) - PROD_W'($signed(pp[LQ][LQ]));
        sum_im = PROD_W'($signed(pp[LI][LQ])) + PROD_W'($signed(pp[LQ][LI]));
        res    = {sum_im[PROD_W-1:DROP_W], sum_re[PROD_W-1:DROP_W]};
    end

    logic unused_low;
    assign unused_low = ^{sum_re[DROP_W-1:0], sum_im[DROP_W-1:0]};

    // Stage 3: register the truncated result.
    always_ff @(posedge clk) begin
        if (en) begin
            out_data <= res;
            l3       <= l2;
        end
    end

    assign out_valid = v3;
    assign out_last  = l3;

    // R7: a result held off does not change.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !en) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    // R8: each stage moves its entry one step when enabled.
    p_step1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && en) |=> v1);
    p_step2_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (v1 && en) |=> v2);
    p_step3_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (v2 && en) |=> out_valid);
endmodule

// File: rtl/cmul_stream.sv
// Complex stream multiplier top.
// Pairs one beat of the sample stream (A) with one beat of the tone stream
// (B) and outputs their complex product, truncated to the upper bits. The
// framing flag follows A. The whole pipeline holds while the output is
// offered and not taken.
module cmul_stream #(
    parameter int A_LANE_W = 24,
    parameter int A_W      = 21,
    parameter int B_W      = 16,
    parameter int DROP_W   = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [2*A_LANE_W-1:0]                s_a_data,
    input  logic                                 s_a_last,
    input  logic                                 s_a_valid,
    output logic                                 s_a_ready,
    input  logic [2*B_W-1:0]                     s_b_data,
    input  logic                                 s_b_last,
    input  logic                                 s_b_valid,
    output logic                                 s_b_ready,
    output logic [2*(A_W+B_W+1-DROP_W)-1:0]      m_data,
    output logic                                 m_last,
    output logic                                 m_valid,
    input  logic                                 m_ready
);
    logic                adv;
    logic                fire;
    logic [1:0][A_W-1:0] a_part;
    logic [1:0][B_W-1:0] b_part;

    // The pipe may move unless a result is offered and not taken.
    assign adv = ~m_valid | m_ready;

    // The tone stream's framing flag is not used.
    logic unused_b_last;
    assign unused_b_last = s_b_last;

    cmul_join u_join (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_valid (s_a_valid),
        .b_valid (s_b_valid),
        .adv     (adv),
        .a_ready (s_a_ready),
        .b_ready (s_b_ready),
        .fire    (fire)
    );

    cmul_lane_split #(.LANE_W(A_LANE_W), .KEEP_W(A_W)) u_split_a (
        .word (s_a_data),
        .part (a_part)
    );

    cmul_lane_split #(.LANE_W(B_W), .KEEP_W(B_W)) u_split_b (
        .word (s_b_data),
        .part (b_part)
    );

    cmul_core #(.A_W(A_W), .B_W(B_W), .DROP_W(DROP_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (adv),
        .in_fire   (fire),
        .in_last   (s_a_last),
        .a_part    (a_part),
        .b_part    (b_part),
        .out_valid (m_valid),
        .out_last  (m_last),
        .out_data  (m_data)
    );

    // R5: nothing is taken from either input while the output is held off.
    p_stall_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |-> (!s_a_ready && !s_b_ready));
    // R9: reset empties the output.
    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> !m_valid);
endmodule

// File: tb/tb_cmul_stream.sv
module tb_cmul_stream;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] s_a_data = '0;
    logic        s_a_last = 1'b0, s_a_valid = 1'b0, s_a_ready;
    logic [31:0] s_b_data = '0;
    logic        s_b_last = 1'b0, s_b_valid = 1'b0, s_b_ready;
    logic [63:0] m_data;
    logic        m_last, m_valid;
    logic        m_ready = 1'b0;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [48:0] stim_a[$];
    logic [32:0] stim_b[$];
    logic [48:0] exp_a[$];
    logic [31:0] exp_b[$];
    int a_pct = 100, b_pct = 100, r_pct = 100;
    bit a_pend = 0, b_pend = 0;
    bit prev_hold = 0;
    logic [63:0] prev_data;
    logic        prev_last;
    bit fired;

    cmul_stream dut (
        .clk(clk), .rst_n(rst_n),
        .s_a_data(s_a_data), .s_a_last(s_a_last), .s_a_valid(s_a_valid), .s_a_ready(s_a_ready),
        .s_b_data(s_b_data), .s_b_last(s_b_last), .s_b_valid(s_b_valid), .s_b_ready(s_b_ready),
        .m_data(m_data), .m_last(m_last), .m_valid(m_valid), .m_ready(m_ready)
    );

    always #5 clk = ~clk;

    // Behavioural reference: exact 38-bit products, keep bits [37:6].
    function automatic logic [63:0] model(logic [47:0] a, logic [31:0] b);
        longint ai, aq, bi, bq, re, im;
        ai = longint'($signed(a[20:0]));
        aq = longint'($signed(a[44:24]));
        bi = longint'($signed(b[15:0]));
        bq = longint'($signed(b[31:16]));
        re = ai * bi - aq * bq;
        im = ai * bq + aq * bi;
        return {im[37:6], re[37:6]};
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, observe just before the rising edge.
    task automatic step();
        bit a_hs, b_hs;
        logic [63:0] e;
        @(negedge clk);
        if (!a_pend) begin
            if (stim_a.size() > 0 && ($urandom % 100) < a_pct) begin
                s_a_valid = 1'b1;
                {s_a_last, s_a_data} = stim_a.pop_front();
            end else begin
                s_a_valid = 1'b0;
                s_a_data = {$urandom, $urandom};
            end
        end
        if (!b_pend) begin
            if (stim_b.size() > 0 && ($urandom % 100) < b_pct) begin
                s_b_valid = 1'b1;
                {s_b_last, s_b_data} = stim_b.pop_front();
            end else begin
                s_b_valid = 1'b0;
                s_b_data = $urandom;
            end
        end
        m_ready = (($urandom % 100) < r_pct);
        #4;
        a_hs = s_a_valid && s_a_ready;
        b_hs = s_b_valid && s_b_ready;
        fired = a_hs;
        if (a_hs || b_hs) check(a_hs == b_hs, "R5 paired acceptance", 64'(a_hs), 64'(b_hs));
        if (a_hs) exp_a.push_back({s_a_last, s_a_data});
        if (b_hs) exp_b.push_back(s_b_data);
        if (prev_hold) begin
            check(m_valid && m_data == prev_data && m_last == prev_last,
                  "R7 held output", {m_data[62:0], m_valid}, {prev_data[62:0], 1'b1});
        end
        if (m_valid && m_ready) begin
            if (exp_a.size() == 0 || exp_b.size() == 0) begin
                check(1'b0, "R5 result without accepted pair", m_data, 64'd0);
            end else begin
                logic [48:0] ea;
                logic [31:0] eb;
                ea = exp_a.pop_front();
                eb = exp_b.pop_front();
                e = model(ea[47:0], eb);
                check(m_data[31:0] == e[31:0], "R3/R1/R2 real part", 64'(m_data[31:0]), 64'(e[31:0]));
                check(m_data[63:32] == e[63:32], "R4/R1/R2 imaginary part", 64'(m_data[63:32]), 64'(e[63:32]));
                check(m_last == ea[48], "R6 last from stream A", 64'(m_last), 64'(ea[48]));
            end
        end
        prev_hold = m_valid && !m_ready;
        prev_data = m_data;
        prev_last = m_last;
        a_pend = s_a_valid && !a_hs;
        b_pend = s_b_valid && !b_hs;
    endtask

    task automatic drain();
        a_pct = 100; b_pct = 100; r_pct = 100;
        for (int k = 0; k < 200 && (stim_a.size() || stim_b.size() || exp_a.size() || exp_b.size()); k++) step();
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state.
        repeat (3) @(posedge clk);
        #1;
        check(!m_valid, "R9 output idle in reset", 64'(m_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #4;
        check(!m_valid, "R9 output idle after reset", 64'(m_valid), 64'd0);

        // R8 and R10: latency with full-scale operands and set guard bits.
        stim_a.push_back({1'b1, 3'b101, 21'h100000, 3'b011, 21'h100000});
        stim_b.push_back({1'b0, 16'h8000, 16'h8000});
        fired = 0;
        for (int k = 0; k < 20 && !fired; k++) step();
        begin
            int n = 0;
            for (int k = 0; k < 10 && !m_valid; k++) begin step(); n++; end
            check(n == 3, "R8 latency", 64'(n), 64'd3);
        end
        // R10: expected {2^30, 0}, checked bit-exactly by the model above.
        check(model({3'b101, 21'h100000, 3'b011, 21'h100000}, 32'h80008000) == {32'h40000000, 32'h0},
              "R10 full-scale reference", model({3'b101, 21'h100000, 3'b011, 21'h100000}, 32'h80008000),
              {32'h40000000, 32'h0});
        stim_a.push_back({1'b0, 3'b111, 21'h0FFFFF, 3'b000, 21'h100000});
        stim_b.push_back({1'b1, 16'h7FFF, 16'h8000});
        drain();

        // R1-R7: random values, independent input gaps, random backpressure.
        for (int phase = 0; phase < 4; phase++) begin
            for (int k = 0; k < 600; k++) begin
                stim_a.push_back({1'($urandom), 24'($urandom), 24'($urandom)});
                stim_b.push_back({1'($urandom), 32'($urandom)});
            end
            case (phase)
                0: begin a_pct = 100; b_pct = 100; r_pct = 100; end
                1: begin a_pct = 40;  b_pct = 90;  r_pct = 70;  end
                2: begin a_pct = 90;  b_pct = 30;  r_pct = 50;  end
                default: begin a_pct = 60; b_pct = 60; r_pct = 20; end
            endcase
            for (int k = 0; k < 6000 && stim_a.size() > 0; k++) step();
            drain();
        end
        // R5: every accepted pair produced exactly one result.
        check(exp_a.size() == 0 && exp_b.size() == 0, "R5 all pairs delivered",
              64'(exp_a.size()), 64'd0);

        // R9: reset mid-stream empties the output.
        stim_a.push_back({1'b1, 48'h000001_000001});
        stim_b.push_back({1'b0, 32'h0001_0001});
        r_pct = 0;
        repeat (5) step();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #4;
        check(!m_valid, "R9 reset flushes pipeline", 64'(m_valid), 64'd0);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule